// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running calendar clock and raises an alarm when the current minute, hour and day of week agree with a programmed alarm setting. The clock logic upstream presents the present minute and hour in BCD, the present weekday as a one-hot vector, and a single-cycle strobe each time the minute advances. The block evaluates the alarm only on that strobe. A hit latches a sticky alarm flag, which in turn drives an active-low, open-drain style interrupt request when interrupts are enabled.

Each of the three alarm fields carries a mask bit in its top position. When that bit is set, the field is treated as matching whatever the time. The weekday field is a set of days rather than a single day, so one setting can fire on several days of the week. Software reaches the block through a single write strobe that carries a new flag value and a new interrupt enable. A written 0 clears the flag, and a written 1 is ignored.

Top module: `alarm_match_irq`

## Requirements
- R1: The minute field is a match when its bit 7 is 1, or when its bits 6:0 equal bits 6:0 of the current BCD minute.
- R2: The hour field is a match when its bit 7 is 1, or when its bits 5:0 equal bits 5:0 of the current 24-hour BCD hour. Bit 6 of the alarm hour is not compared.
- R3: In the weekday field, bits 0 to 6 stand for Sunday through Saturday. The field is a match when its bit 7 is 1, or when any of its set bits 6:0 coincides with the one-hot current weekday.
- R4: When the minute strobe is high at a clock edge and all three fields match, the alarm flag reads 1 after that edge. Without the strobe, the flag is never set.
- R5: A write that carries flag value 1 leaves the flag unchanged.
- R6: A write that carries flag value 0 clears the flag after the edge. If a set condition from R4 occurs on the same edge, the set takes priority and the flag reads 1.
- R7: Every write strobe loads the interrupt enable. The interrupt output-enable is 1 and the active-low request is 0 exactly when both the flag and the enable are 1. Otherwise the output-enable is 0 and the request is 1.
- R8: After reset, the flag and the enable are both 0. Once set, the flag stays at 1 until a write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| min_tick_i | input | 1 | Single-cycle strobe marking a minute update |
| now_min_i | input | 8 | Current minute, BCD |
| now_hour_i | input | 8 | Current hour, BCD, 24-hour format |
| now_wday_i | input | 7 | Current weekday, one-hot, bit 0 is Sunday |
| alm_min_i | input | 8 | Alarm minute; bit 7 masks the field |
| alm_hour_i | input | 8 | Alarm hour; bit 7 masks the field |
| alm_wday_i | input | 8 | Alarm weekday set; bit 7 masks the field |
| wr_i | input | 1 | Write strobe for flag and enable |
| wr_flag_i | input | 1 | Flag value written; only 0 has an effect |
| wr_ien_i | input | 1 | Interrupt enable value written |
| flag_o | output | 1 | Sticky alarm flag |
| irq_n_o | output | 1 | Interrupt request, active low |
| irq_oe_o | output | 1 | Output-enable for the interrupt line |

## Verification
The hardest case to reach is the edge where a matching minute strobe and a software clear of the flag arrive together, because only the priority rule decides the outcome. The stimulus sets the flag, leaves the time on a matching minute, and then issues the strobe and a clearing write in the same cycle. The stimulus also checks the partial-mask cases: a weekday set that covers two days, tested on a day inside the set and on a day outside it, and an alarm hour whose uncompared bit 6 holds a stray value.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned MASK_BIT = REG_W - 1;

    typedef struct packed {
        logic flag;
        logic ien;
    } alarm_state_t;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int unsigned W        = 8,
    parameter int unsigned CMP_BITS = 7
) (
    input  logic [W-1:0] alarm_i,
    input  logic [W-1:0] now_i,
    output logic         hit_o
);
    logic masked;
    logic equal;

    assign masked = alarm_i[W-1];
    assign equal  = (alarm_i[CMP_BITS-1:0] == now_i[CMP_BITS-1:0]);
    assign hit_o  = masked | equal;
endmodule

// File: rtl/alarm_day_cmp.sv
module alarm_day_cmp #(
    parameter int unsigned W    = 8,
    parameter int unsigned DAYS = 7
) (
    input  logic [W-1:0]    alarm_i,
    input  logic [DAYS-1:0] now_i,
    output logic            hit_o
);
    logic [DAYS-1:0] overlap;

    for (genvar d = 0; d < DAYS; d++) begin : g_day
        assign overlap[d] = alarm_i[d] & now_i[d];
    end

    assign hit_o = alarm_i[W-1] | (|overlap);
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl
    import alarm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic wr_i,
    input  logic wr_flag_i,
    input  logic wr_ien_i,
    output logic flag_o,
    output logic ien_o
);
    alarm_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            state_d.ien = wr_ien_i;
            if (!wr_flag_i) begin
                state_d.flag = 1'b0;
            end
        end
        if (set_i) begin
            state_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_o = state_q.flag;
    assign ien_o  = state_q.ien;
endmodule

// File: rtl/alarm_match_irq.sv
module alarm_match_irq
    import alarm_pkg::*;
#(
    parameter int unsigned MIN_BITS  = 7,
    parameter int unsigned HOUR_BITS = 6,
    parameter int unsigned DAYS      = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             min_tick_i,
    input  logic [REG_W-1:0] now_min_i,
    input  logic [REG_W-1:0] now_hour_i,
    input  logic [DAYS-1:0]  now_wday_i,
    input  logic [REG_W-1:0] alm_min_i,
    input  logic [REG_W-1:0] alm_hour_i,
    input  logic [REG_W-1:0] alm_wday_i,
    input  logic             wr_i,
    input  logic             wr_flag_i,
    input  logic             wr_ien_i,
    output logic             flag_o,
    output logic             irq_n_o,
    output logic             irq_oe_o
);
    logic min_hit;
    logic hour_hit;
    logic day_hit;
    logic set;
    logic ien;

    alarm_field_cmp #(.W(REG_W), .CMP_BITS(MIN_BITS)) u_min_cmp (
        .alarm_i (alm_min_i),
        .now_i   (now_min_i),
        .hit_o   (min_hit)
    );

    alarm_field_cmp #(.W(REG_W), .CMP_BITS(HOUR_BITS)) u_hour_cmp (
        .alarm_i (alm_hour_i),
        .now_i   (now_hour_i),
        .hit_o   (hour_hit)
    );

    alarm_day_cmp #(.W(REG_W), .DAYS(DAYS)) u_day_cmp (
        .alarm_i (alm_wday_i),
        .now_i   (now_wday_i),
        .hit_o   (day_hit)
    );

    assign set = min_tick_i & min_hit & hour_hit & day_hit;

    alarm_flag_ctl u_flag (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (set),
        .wr_i      (wr_i),
        .wr_flag_i (wr_flag_i),
        .wr_ien_i  (wr_ien_i),
        .flag_o    (flag_o),
        .ien_o     (ien)
    );

    assign irq_oe_o = flag_o & ien;
    assign irq_n_o  = ~irq_oe_o;
endmodule

// File: rtl/alarm_match_irq_chk.sv
module alarm_match_irq_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       min_tick_i,
    input logic [7:0] now_min_i,
    input logic [7:0] now_hour_i,
    input logic [6:0] now_wday_i,
    input logic [7:0] alm_min_i,
    input logic [7:0] alm_hour_i,
    input logic [7:0] alm_wday_i,
    input logic       wr_i,
    input logic       wr_flag_i,
    input logic       flag_o,
    input logic       irq_n_o,
    input logic       irq_oe_o
);
    logic full_match;
    assign full_match = (alm_min_i[7] || alm_min_i[6:0] == now_min_i[6:0])
                     && (alm_hour_i[7] || alm_hour_i[5:0] == now_hour_i[5:0])
                     && (alm_wday_i[7] || (alm_wday_i[6:0] & now_wday_i) != 7'd0);

    // R4 / R1 / R2 / R3
    a_r4_set_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (min_tick_i && full_match) |=> flag_o);

    // R4: only a strobe raises the flag
    a_r4_rise_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_o) |-> $past(min_tick_i));

    // R6
    a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !wr_flag_i && !min_tick_i) |=> !flag_o);

    // R8 / R5
    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !(wr_i && !wr_flag_i)) |=> flag_o);

    // R7
    a_r7_oe_pulls_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_oe_o |-> (!irq_n_o && flag_o));

    a_r7_no_flag_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag_o |-> (!irq_oe_o && irq_n_o));
endmodule

bind alarm_match_irq alarm_match_irq_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .min_tick_i (min_tick_i),
    .now_min_i  (now_min_i),
    .now_hour_i (now_hour_i),
    .now_wday_i (now_wday_i),
    .alm_min_i  (alm_min_i),
    .alm_hour_i (alm_hour_i),
    .alm_wday_i (alm_wday_i),
    .wr_i       (wr_i),
    .wr_flag_i  (wr_flag_i),
    .flag_o     (flag_o),
    .irq_n_o    (irq_n_o),
    .irq_oe_o   (irq_oe_o)
);

// File: tb/alarm_match_irq_tb_top.sv
module alarm_match_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] n_min = '0, n_hour = '0;
    logic [6:0] n_wday = 7'h01;
    logic [7:0] a_min = '0, a_hour = '0, a_wday = '0;
    logic       wr = 1'b0, wr_flag = 1'b0, wr_ien = 1'b0;
    logic       flag, irq_n, irq_oe;

    int checks = 0;
    int fails  = 0;
    bit exp_flag = 1'b0;
    bit exp_ien  = 1'b0;

    always #4 clk = ~clk;

    alarm_match_irq dut_i (
        .clk_i (clk), .rst_ni (rst_n), .min_tick_i (tick),
        .now_min_i (n_min), .now_hour_i (n_hour), .now_wday_i (n_wday),
        .alm_min_i (a_min), .alm_hour_i (a_hour), .alm_wday_i (a_wday),
        .wr_i (wr), .wr_flag_i (wr_flag), .wr_ien_i (wr_ien),
        .flag_o (flag), .irq_n_o (irq_n), .irq_oe_o (irq_oe)
    );

    function automatic bit model_match();
        bit m, h, d;
        m = a_min[7]  || (a_min[6:0] == n_min[6:0]);
        h = a_hour[7] || (a_hour[5:0] == n_hour[5:0]);
        d = a_wday[7];
        for (int i = 0; i < 7; i++) if (a_wday[i] && n_wday[i]) d = 1'b1;
        return m && h && d;
    endfunction

    task automatic compare(input string tag);
        bit e_oe;
        e_oe = exp_flag && exp_ien;
        checks++;
        if (flag !== exp_flag || irq_oe !== e_oe || irq_n !== !e_oe) begin
            fails++;
            $display("FAIL %s: flag/oe/irq_n actual %b%b%b expected %b%b%b",
                     tag, flag, irq_oe, irq_n, exp_flag, e_oe, !e_oe);
        end
    endtask

    task automatic cyc(input bit t, input bit w, input bit wf, input bit wi, input string tag);
        tick = t; wr = w; wr_flag = wf; wr_ien = wi;
        @(posedge clk);
        if (w) exp_ien = wi;
        if (t && model_match()) exp_flag = 1'b1;
        else if (w && !wf) exp_flag = 1'b0;
        @(negedge clk);
        tick = 1'b0; wr = 1'b0;
        compare(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R8 reset");
        rst_n = 1'b1;
        @(negedge clk);
        cyc(0, 1, 0, 1, "R7 enable write");
        a_min = 8'h30; a_hour = 8'h07; a_wday = 8'h02;
        n_min = 8'h30; n_hour = 8'h07; n_wday = 7'h02;
        cyc(0, 0, 0, 0, "R4 match without tick");
        cyc(1, 0, 0, 0, "R4 full match");
        cyc(0, 0, 0, 0, "R8 flag holds");
        cyc(0, 1, 1, 1, "R5 write one ignored");
        cyc(0, 1, 0, 1, "R6 clear");
        n_min = 8'h31;
        cyc(1, 0, 0, 0, "R1 minute mismatch");
        n_min = 8'h30; n_hour = 8'h08;
        cyc(1, 0, 0, 0, "R2 hour mismatch");
        a_hour = 8'h47; n_hour = 8'h07;
        cyc(1, 0, 0, 0, "R2 bit6 not compared");
        cyc(0, 1, 0, 1, "R6 clear");
        a_min = 8'h92; n_min = 8'h45;
        cyc(1, 0, 0, 0, "R1 minute masked");
        cyc(0, 1, 0, 1, "R6 clear");
        a_wday = 8'h41; n_wday = 7'h04;
        cyc(1, 0, 0, 0, "R3 day outside set");
        n_wday = 7'h40;
        cyc(1, 0, 0, 0, "R3 Saturday in set");
        cyc(0, 1, 0, 1, "R6 clear");
        n_wday = 7'h01;
        cyc(1, 0, 0, 0, "R3 Sunday in set");
        cyc(1, 1, 0, 1, "R6 set beats clear");
        cyc(0, 1, 1, 0, "R7 enable off");
        cyc(0, 0, 0, 0, "R7 flag without enable");
        cyc(0, 1, 1, 1, "R7 enable back on");
        cyc(0, 1, 0, 1, "R6 clear");
        a_wday = 8'h80; n_wday = 7'h10; a_hour = 8'h85; n_hour = 8'h23;
        cyc(1, 0, 0, 0, "R3 weekday masked");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule